// File: doc/BRIEF.md
# Row Readout Phase and Bias Sequencer

This block paces the rolling-shutter readout of an image array shared by multi-column converter groups. Each row period has two phases. The first is a pixel phase: a reset slot, then a signal-sampling slot. The second is a conversion phase in which every column of a group is digitised in turn, one fixed-length slot per column. All groups are driven by the same control outputs. The block raises a high-bias select for the comparator pre-amplifier only while conversions run. For the rest of the row it leaves the low-bias level selected, which saves static current.

The column scan direction reverses on every row. The last column converted in one row is then the first column converted in the next row. A converter that reuses the upper bits of its previous result therefore always starts from a physically adjacent pixel, and no per-row storage of a first-column result is needed. Only the very first conversion of a frame has no neighbour, and the block flags that one as a full conversion. Slot lengths, the column count and the row count are parameters.

While the enable input is low, the block sits idle at the start of a frame. Once enabled, it runs frame after frame.

Top module: `row_phase_seq`

## Requirements
- R1: With reset high, or in the cycle after enable is sampled low, the reset strobe, sample strobe, bias select, conversion start, full-conversion flag and frame start are all 0, and the row and column outputs are 0.
- R2: One row period lasts RST_CYC + SMP_CYC + NCOL*CONV_CYC cycles. The reset strobe is high for the first RST_CYC cycles, and the sample strobe is high for the next SMP_CYC cycles.
- R3: The bias select is 1 exactly during the NCOL*CONV_CYC conversion cycles of each row. It is 0 during the reset and sample slots, and it rises only in the cycle right after a sample-strobe cycle.
- R4: The conversion start is a one-cycle pulse in the first cycle of each CONV_CYC-long column slot, NCOL pulses per row. The column output holds the column index for the whole slot and is 0 outside the conversion phase.
- R5: Rows with an even row index (row 0 is the first row of the sensor's odd/even pairing) scan columns 0 up to NCOL-1. Rows with an odd index scan NCOL-1 down to 0.
- R6: The scan-direction output is 0 on ascending rows and 1 on descending rows, so it toggles at every row change, including the wrap from row NROW-1 to row 0 (NROW is even).
- R7: The row output advances by one at the end of each row period and wraps from NROW-1 to 0.
- R8: The frame start is a one-cycle pulse in the first reset cycle of row 0, once per frame.
- R9: The full-conversion flag is 1 only with the first conversion start of row 0. Every other conversion start has it at 0 (delta conversion).
- R10: After enable is dropped and raised again, the sequence restarts at row 0. The frame start appears at the second rising edge that samples enable high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low holds the sequencer idle at frame start |
| pix_rst_o | output | 1 | Pixel reset strobe |
| pix_smp_o | output | 1 | Pixel signal sample strobe |
| bias_hi_o | output | 1 | 1 selects high pre-amplifier bias, 0 the low bias |
| row_o | output | ROWW | Current row index |
| scan_desc_o | output | 1 | Column scan direction, 1 = descending |
| conv_go_o | output | 1 | One-cycle start of a column conversion |
| col_o | output | COLW | Column index being converted |
| full_conv_o | output | 1 | Marks a conversion that must resolve all bits |
| frame_go_o | output | 1 | One-cycle frame start |

## Verification
The bench goes after the row boundary where the last column slot hands over to the next reset slot. A design off by one there would stretch or shorten the row, and the bias select would overlap a reset cycle. It also targets the wrap from the last row to row 0. A design with a wrong row limit or wrong parity would repeat a scan direction, which breaks the adjacent-pixel chain, or it would miss the frame start and full-conversion flag. Enable is dropped partway through a row to catch a sequencer that resumes mid-row instead of restarting the frame. A second reset during a run checks that a stale row counter or a stale bias level does not survive it.

// File: rtl/rps_pkg.sv
package rps_pkg;
  typedef enum logic [1:0] {
    PH_RST  = 2'd0,
    PH_SMP  = 2'd1,
    PH_CONV = 2'd2
  } phase_t;
endpackage

// File: rtl/rps_slot_timer.sv
module rps_slot_timer
  import rps_pkg::*;
#(
  parameter int RST_CYC  = 4,
  parameter int SMP_CYC  = 4,
  parameter int CONV_CYC = 12,
  parameter int NCOL     = 16,
  parameter int CW       = 4,
  parameter int COLW     = 4
) (
  input  logic            clk,
  input  logic            clr,
  input  logic            adv,
  output phase_t          phase,
  output logic [CW-1:0]   cyc,
  output logic [COLW-1:0] slot,
  output logic            row_end
);
  localparam logic [CW-1:0]   RST_LAST  = CW'(RST_CYC - 1);
  localparam logic [CW-1:0]   SMP_LAST  = CW'(SMP_CYC - 1);
  localparam logic [CW-1:0]   CONV_LAST = CW'(CONV_CYC - 1);
  localparam logic [COLW-1:0] COL_LAST  = COLW'(NCOL - 1);

  logic slot_done;

  always_comb begin
    unique case (phase)
      PH_RST:  slot_done = (cyc == RST_LAST);
      PH_SMP:  slot_done = (cyc == SMP_LAST);
      default: slot_done = (cyc == CONV_LAST);
    endcase
  end

  assign row_end = adv && (phase == PH_CONV) && slot_done && (slot == COL_LAST);

  always_ff @(posedge clk) begin
    if (clr) begin
      phase <= PH_RST;
      cyc   <= '0;
      slot  <= '0;
    end else if (adv) begin
      if (!slot_done) begin
        cyc <= cyc + 1'b1;
      end else begin
        cyc <= '0;
        unique case (phase)
          PH_RST: phase <= PH_SMP;
          PH_SMP: begin
            phase <= PH_CONV;
            slot  <= '0;
          end
          default: begin
            if (slot == COL_LAST) begin
              phase <= PH_RST;
              slot  <= '0;
            end else begin
              slot <= slot + 1'b1;
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/rps_row_tracker.sv
module rps_row_tracker #(
  parameter int NROW = 120,
  parameter int ROWW = 7
) (
  input  logic            clk,
  input  logic            clr,
  input  logic            row_end,
  output logic [ROWW-1:0] row
);
  localparam logic [ROWW-1:0] ROW_LAST = ROWW'(NROW - 1);

  always_ff @(posedge clk) begin
    if (clr) begin
      row <= '0;
    end else if (row_end) begin
      row <= (row == ROW_LAST) ? '0 : row + 1'b1;
    end
  end
endmodule

// File: rtl/rps_col_mapper.sv
module rps_col_mapper #(
  parameter int NCOL = 16,
  parameter int COLW = 4,
  parameter bit ALTERNATE = 1'b1
) (
  input  logic [COLW-1:0] slot,
  input  logic            desc,
  output logic [COLW-1:0] col
);
  localparam logic [COLW-1:0] COL_LAST = COLW'(NCOL - 1);

  generate
    if (ALTERNATE) begin : g_alt
      assign col = desc ? (COL_LAST - slot) : slot;
    end else begin : g_fixed
      logic unused_desc;
      assign unused_desc = desc;
      assign col = slot;
    end
  endgenerate
endmodule

// File: rtl/row_phase_seq.sv
module row_phase_seq
  import rps_pkg::*;
#(
  parameter int RST_CYC  = 4,
  parameter int SMP_CYC  = 4,
  parameter int CONV_CYC = 12,
  parameter int NCOL     = 16,
  parameter int NROW     = 120,
  localparam int MAXC    = (RST_CYC > SMP_CYC) ?
                           ((RST_CYC > CONV_CYC) ? RST_CYC : CONV_CYC) :
                           ((SMP_CYC > CONV_CYC) ? SMP_CYC : CONV_CYC),
  localparam int CW      = $clog2(MAXC + 1),
  localparam int COLW    = (NCOL > 1) ? $clog2(NCOL) : 1,
  localparam int ROWW    = (NROW > 1) ? $clog2(NROW) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  output logic            pix_rst_o,
  output logic            pix_smp_o,
  output logic            bias_hi_o,
  output logic [ROWW-1:0] row_o,
  output logic            scan_desc_o,
  output logic            conv_go_o,
  output logic [COLW-1:0] col_o,
  output logic            full_conv_o,
  output logic            frame_go_o
);
  logic            clr;
  logic            live;
  phase_t          phase;
  logic [CW-1:0]   cyc;
  logic [COLW-1:0] slot;
  logic            row_end;
  logic [ROWW-1:0] row;
  logic [COLW-1:0] col;
  logic            desc;
  logic            in_conv;
  logic            go_now;

  assign clr = rst | ~en;

  rps_slot_timer #(
    .RST_CYC(RST_CYC), .SMP_CYC(SMP_CYC), .CONV_CYC(CONV_CYC),
    .NCOL(NCOL), .CW(CW), .COLW(COLW)
  ) u_timer (
    .clk(clk), .clr(clr), .adv(live),
    .phase(phase), .cyc(cyc), .slot(slot), .row_end(row_end)
  );

  rps_row_tracker #(.NROW(NROW), .ROWW(ROWW)) u_rows (
    .clk(clk), .clr(clr), .row_end(row_end), .row(row)
  );

  assign desc = row[0];

  rps_col_mapper #(.NCOL(NCOL), .COLW(COLW), .ALTERNATE(1'b1)) u_cols (
    .slot(slot), .desc(desc), .col(col)
  );

  assign in_conv = (phase == PH_CONV);
  assign go_now  = in_conv && (cyc == '0);

  always_ff @(posedge clk) begin
    if (clr) begin
      live        <= 1'b0;
      pix_rst_o   <= 1'b0;
      pix_smp_o   <= 1'b0;
      bias_hi_o   <= 1'b0;
      row_o       <= '0;
      scan_desc_o <= 1'b0;
      conv_go_o   <= 1'b0;
      col_o       <= '0;
      full_conv_o <= 1'b0;
      frame_go_o  <= 1'b0;
    end else begin
      live        <= 1'b1;
      pix_rst_o   <= live && (phase == PH_RST);
      pix_smp_o   <= live && (phase == PH_SMP);
      bias_hi_o   <= live && in_conv;
      row_o       <= row;
      scan_desc_o <= desc;
      conv_go_o   <= live && go_now;
      col_o       <= (live && in_conv) ? col : '0;
      full_conv_o <= live && go_now && (row == '0) && (slot == '0);
      frame_go_o  <= live && (phase == PH_RST) && (cyc == '0) && (row == '0);
    end
  end
endmodule

// File: rtl/rps_checker.sv
module rps_checker #(
  parameter int ROWW = 7
) (
  input logic            clk,
  input logic            rst,
  input logic            en,
  input logic            pix_rst_o,
  input logic            pix_smp_o,
  input logic            bias_hi_o,
  input logic [ROWW-1:0] row_o,
  input logic            scan_desc_o,
  input logic            conv_go_o,
  input logic            full_conv_o,
  input logic            frame_go_o
);
  assert_idle_when_off_R1: assert property (@(posedge clk) disable iff (rst)
    !en |=> !(pix_rst_o || pix_smp_o || bias_hi_o || conv_go_o || frame_go_o));

  assert_bias_exclusive_R3: assert property (@(posedge clk) disable iff (rst)
    bias_hi_o |-> !(pix_rst_o || pix_smp_o));

  assert_bias_rise_after_sample_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(bias_hi_o) |-> $past(pix_smp_o));

  assert_start_in_conv_R4: assert property (@(posedge clk) disable iff (rst)
    conv_go_o |-> bias_hi_o);

  assert_dir_toggles_R6: assert property (@(posedge clk) disable iff (rst)
    (en && $past(en) && (row_o != $past(row_o))) |-> (scan_desc_o != $past(scan_desc_o)));

  assert_frame_at_row0_R8: assert property (@(posedge clk) disable iff (rst)
    frame_go_o |-> (pix_rst_o && (row_o == '0) && !scan_desc_o));

  assert_full_first_only_R9: assert property (@(posedge clk) disable iff (rst)
    full_conv_o |-> (conv_go_o && (row_o == '0)));
endmodule

bind row_phase_seq rps_checker #(.ROWW(ROWW)) u_rps_chk (
  .clk(clk), .rst(rst), .en(en),
  .pix_rst_o(pix_rst_o), .pix_smp_o(pix_smp_o), .bias_hi_o(bias_hi_o),
  .row_o(row_o), .scan_desc_o(scan_desc_o), .conv_go_o(conv_go_o),
  .full_conv_o(full_conv_o), .frame_go_o(frame_go_o)
);

// File: tb/tb_row_phase_seq.sv
`timescale 1ns/1ps
module tb_row_phase_seq;
  localparam int RST_CYC  = 4;
  localparam int SMP_CYC  = 4;
  localparam int CONV_CYC = 12;
  localparam int NCOL     = 16;
  localparam int NROW     = 120;
  localparam int ROWW     = 7;
  localparam int COLW     = 4;
  localparam int ROWLEN   = RST_CYC + SMP_CYC + NCOL * CONV_CYC;
  localparam int FRAME    = ROWLEN * NROW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic            pix_rst_o, pix_smp_o, bias_hi_o, scan_desc_o;
  logic            conv_go_o, full_conv_o, frame_go_o;
  logic [ROWW-1:0] row_o;
  logic [COLW-1:0] col_o;

  always #5 clk = ~clk;

  row_phase_seq #(
    .RST_CYC(RST_CYC), .SMP_CYC(SMP_CYC), .CONV_CYC(CONV_CYC),
    .NCOL(NCOL), .NROW(NROW)
  ) dut (
    .clk(clk), .rst(rst), .en(en),
    .pix_rst_o(pix_rst_o), .pix_smp_o(pix_smp_o), .bias_hi_o(bias_hi_o),
    .row_o(row_o), .scan_desc_o(scan_desc_o), .conv_go_o(conv_go_o),
    .col_o(col_o), .full_conv_o(full_conv_o), .frame_go_o(frame_go_o)
  );

  int n_chk  = 0;
  int n_fail = 0;
  int pos    = -1;
  bit seen_edge = 0;
  int e_rst, e_smp, e_bias, e_row, e_desc, e_go, e_col, e_full, e_frame;

  task automatic chk(string tag, string what, int act, int expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s %s at %0t: actual %0d expected %0d", tag, what, $time, act, expv);
    end
  endtask

  // Behavioural reference: position in frame, decoded one cycle later.
  always @(posedge clk) begin
    seen_edge = 1;
    e_rst = 0; e_smp = 0; e_bias = 0; e_row = 0; e_desc = 0;
    e_go = 0; e_col = 0; e_full = 0; e_frame = 0;
    if (rst || !en) begin
      pos = -1;
    end else begin
      if (pos >= 0) begin
        int r, off, c, s;
        r   = pos / ROWLEN;
        off = pos % ROWLEN;
        e_row  = r;
        e_desc = r % 2;
        e_rst  = (off < RST_CYC);
        e_smp  = (off >= RST_CYC) && (off < RST_CYC + SMP_CYC);
        e_bias = (off >= RST_CYC + SMP_CYC);
        e_frame = (pos == 0);
        if (e_bias) begin
          c = off - RST_CYC - SMP_CYC;
          s = c / CONV_CYC;
          e_go  = (c % CONV_CYC == 0);
          e_col = (r % 2 == 0) ? s : NCOL - 1 - s;
          e_full = e_go && (r == 0) && (s == 0);
        end
      end
      pos = (pos + 1) % FRAME;
    end
  end

  always @(negedge clk) begin
    if (seen_edge) begin
      string idle;
      idle = (e_rst == 0 && e_smp == 0 && e_bias == 0 && e_row == 0) ? "R1" : "";
      chk((idle != "") ? "R1" : "R2", "reset strobe", int'(pix_rst_o), e_rst);
      chk((idle != "") ? "R1" : "R2", "sample strobe", int'(pix_smp_o), e_smp);
      chk("R3", "bias select", int'(bias_hi_o), e_bias);
      chk("R4", "conversion start", int'(conv_go_o), e_go);
      chk("R5", "column", int'(col_o), e_col);
      chk("R6", "scan direction", int'(scan_desc_o), e_desc);
      chk("R7", "row", int'(row_o), e_row);
      chk("R8", "frame start", int'(frame_go_o), e_frame);
      chk("R9", "full conversion", int'(full_conv_o), e_full);
    end
  end

  task automatic cycles(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int frames;
    cycles(3);
    // R1: reset state
    chk("R1", "bias in reset", int'(bias_hi_o), 0);
    chk("R1", "row in reset", int'(row_o), 0);
    rst = 1'b0;
    cycles(4);
    chk("R1", "frame start while disabled", int'(frame_go_o), 0);
    en = 1'b1;
    cycles(2);
    chk("R10", "first frame start", int'(frame_go_o), 1);
    // Run past the wrap from the last row back to row 0.
    frames = 0;
    for (int i = 0; i < FRAME + 600; i++) begin
      @(negedge clk);
      if (frame_go_o) frames++;
    end
    chk("R8", "frame starts after wrap", frames, 1);
    // Drop enable mid-row, then restart.
    cycles(37);
    en = 1'b0;
    cycles(5);
    chk("R1", "idle after disable", int'(pix_rst_o | pix_smp_o | bias_hi_o), 0);
    en = 1'b1;
    cycles(1);
    chk("R10", "no start yet", int'(frame_go_o), 0);
    cycles(1);
    chk("R10", "restart frame start", int'(frame_go_o), 1);
    chk("R10", "restart row", int'(row_o), 0);
    cycles(700);
    rst = 1'b1;
    cycles(2);
    chk("R1", "bias after reset", int'(bias_hi_o), 0);
    rst = 1'b0;
    cycles(300);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule